// File: doc/BRIEF.md
# Serial Transmit Path with Line Break Insertion

This block turns bytes into asynchronous serial frames on one output line. Bytes are written into a first-in first-out queue and taken one at a time into a shift register, which sends one start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Each bit lasts a fixed number of pulses of an oversampling baud tick that comes from outside the block. Data width, parity and stop count are set by static configuration inputs. The block reads them once per frame, at the moment the frame starts.

A break request drives the line low for longer than a full frame. The break waits for any frame already in progress to end. It then runs before any further queued bytes, and normal transmission picks up again on its own afterwards. When flow control is enabled, a high level on the peer-ready input stops new frames from starting but never cuts a frame short. A level interrupt output shows that the queue is empty and the line has gone quiet.

Top module: `uart_tx_brk`

## Requirements
- R1: A frame is a start bit (0), then the data bits least significant first, then the optional parity bit, then the stop bits (1). The data bit count is 5 + `cfg_len` (0→5, 1→6, 2→7, 3→8). `cfg_two_stop`=1 gives two stop bits and 0 gives one.
- R2: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 makes the count of ones in data plus parity even, and 1 makes it odd. With `cfg_par_en`=0 no parity bit is sent.
- R3: `ser_out` is 1 while idle. A frame or break starts on the first cycle that `baud_tick` is high while the block is idle, and `ser_out` changes on the following cycle. Each bit then lasts `TICKS_PER_BIT` ticks.
- R4: The queue holds up to `DEPTH` bytes and sends them in write order. `fifo_level` is the byte count, with `fifo_full` and `fifo_empty` to match. A write that arrives while full is dropped. A byte leaves the queue in the cycle its frame starts.
- R5: The configuration is taken when a frame starts. Changing it during a frame does not alter that frame.
- R6: A one-cycle pulse on `brk_req` is remembered until it is served. The break starts only after the frame in progress has ended. It holds `ser_out` at 0 for N+1 bit times, where N is the frame length in bits under the configuration when the break starts.
- R7: A pending break is served before any queued byte. After it, queued bytes are sent with no further request. Flow control does not hold back a break.
- R8: With `cfg_flow_en`=1 and `peer_ready_n`=1, no new frame starts and the queue is untouched. Raising `peer_ready_n` during a frame lets that frame finish. With `cfg_flow_en`=0, `peer_ready_n` has no effect.
- R9: `tx_idle_irq` is 1 exactly when the queue is empty, no frame or break is in progress and no break is pending.
- R10: After reset, `ser_out`=1, `fifo_level`=0, `fifo_empty`=1, `fifo_full`=0 and `tx_idle_irq`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par_en | input | 1 | Add parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_flow_en | input | 1 | Gate frame starts on peer_ready_n |
| brk_req | input | 1 | Request a line break |
| baud_tick | input | 1 | Oversampling tick, TICKS_PER_BIT per bit |
| peer_ready_n | input | 1 | Peer ready, active low |
| ser_out | output | 1 | Serial line |
| fifo_level | output | $clog2(DEPTH+1) | Bytes queued |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| tx_idle_irq | output | 1 | Queue empty and line idle |

## Verification
The bench builds the block with DEPTH=4 and TICKS_PER_BIT=4, and gives it a baud tick on every second clock. A small queue fills after a few writes, so the dropped-write and full paths come up early. Short bits keep every combination of data width, parity and stop count within a few thousand cycles. A behavioural model made of a byte queue and a list of pending line levels is compared with every output on every clock. Targeted scenarios cover a mid-frame configuration change, flow-control stalls that begin inside a frame, and a break raised during a frame with bytes still queued. The break scenario also measures the length of the low run directly.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DEPTH = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_flow_en,
  input  logic          brk_req,
  input  logic          baud_tick,
  input  logic          peer_ready_n,
  output logic          ser_out,
  output logic [CW-1:0] fifo_level,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          tx_idle_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_BRK} st_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  st_t           st;
  logic [11:0]   sh, fv;
  logic [3:0]    left, nbits;
  logic [TW-1:0] tcnt;
  logic          brk_pend;
  logic [7:0]    dm;

  assign fifo_level  = cnt;
  assign fifo_full   = (cnt == CW'(DEPTH));
  assign fifo_empty  = (cnt == '0);
  assign tx_idle_irq = fifo_empty && st == S_IDLE && !brk_pend;
  assign ser_out     = (st == S_FRAME) ? sh[0] : (st != S_BRK);

  wire cts_ok  = !cfg_flow_en || !peer_ready_n;
  wire go      = st == S_IDLE && baud_tick && (brk_pend || (!fifo_empty && cts_ok));
  wire go_brk  = go && brk_pend;
  wire go_frm  = go && !brk_pend;
  wire push    = wr_en && !fifo_full;
  wire bit_end = st != S_IDLE && baud_tick && tcnt == TW'(TICKS_PER_BIT - 1);

  assign nbits = 4'd7 + {2'b0, cfg_len} + {3'b0, cfg_par_en} + {3'b0, cfg_two_stop};

  always_comb begin
    dm = mem[rp] & (8'hFF >> (2'd3 - cfg_len));
    fv = 12'hFFF;
    fv[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 5 + int'(cfg_len)) fv[1 + i] = dm[i];
    if (cfg_par_en) fv[4'd6 + {2'b0, cfg_len}] = (^dm) ^ cfg_par_odd;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (go_frm) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, go_frm})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '1;
      left     <= '0;
      tcnt     <= '0;
      brk_pend <= 1'b0;
    end else begin
      brk_pend <= brk_req || (brk_pend && !go_brk);
      if (go_brk) begin
        st   <= S_BRK;
        left <= nbits + 4'd1;
        tcnt <= '0;
      end else if (go_frm) begin
        st   <= S_FRAME;
        sh   <= fv;
        left <= nbits;
        tcnt <= '0;
      end else if (bit_end) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[11:1]};
        if (left == 4'd1) st <= S_IDLE;
        else left <= left - 4'd1;
      end else if (st != S_IDLE && baud_tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !go_frm) |=> fifo_full && $stable(fifo_level)); // R4
  AST_POP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRAME && $past(st) == S_IDLE && !$past(wr_en)) |-> fifo_level == $past(fifo_level) - 1'b1); // R4
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(ser_out)); // R3
  AST_BREAK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FRAME |=> st != S_BRK); // R6
  AST_FLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_flow_en && peer_ready_n && !brk_pend) |=> st != S_FRAME); // R8
  AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && brk_pend) |=> st != S_FRAME); // R7
endmodule

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;
  localparam int DEPTH = 4;
  localparam int TPB = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, brk_req = 0, baud_tick = 0, peer_ready_n = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_flow_en = 0;
  logic ser_out, fifo_full, fifo_empty, tx_idle_irq;
  logic [CW-1:0] fifo_level;

  uart_tx_brk #(.DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_flow_en(cfg_flow_en), .brk_req(brk_req), .baud_tick(baud_tick),
    .peer_ready_n(peer_ready_n), .ser_out(ser_out), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_idle_irq(tx_idle_irq));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  string cur_req = "R10";
  bit chk_en = 0;

  int q[$];
  int line[$];
  int mmode = 0, mtc = 0;
  bit mbp = 0, was_full, sbrk;
  int b, L, n, p;

  function automatic int frame_len();
    return 7 + int'(cfg_len) + int'(cfg_par_en) + int'(cfg_two_stop);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); line.delete(); mmode = 0; mtc = 0; mbp = 0;
    end else begin
      was_full = (q.size() == DEPTH);
      sbrk = 0;
      if (mmode == 0 && baud_tick) begin
        if (mbp) begin
          n = frame_len();
          for (int k = 0; k <= n; k++) line.push_back(0);
          mmode = 2; mtc = 0; sbrk = 1;
        end else if (q.size() > 0 && (!cfg_flow_en || !peer_ready_n)) begin
          b = q.pop_front();
          L = 5 + int'(cfg_len);
          p = cfg_par_odd;
          line.push_back(0);
          for (int i = 0; i < L; i++) begin
            line.push_back((b >> i) & 1);
            p = p ^ ((b >> i) & 1);
          end
          if (cfg_par_en) line.push_back(p);
          line.push_back(1);
          if (cfg_two_stop) line.push_back(1);
          mmode = 1; mtc = 0;
        end
      end else if (mmode != 0 && baud_tick) begin
        mtc++;
        if (mtc == TPB) begin
          mtc = 0;
          void'(line.pop_front());
          if (line.size() == 0) mmode = 0;
        end
      end
      mbp = brk_req || (mbp && !sbrk);
      if (wr_en && !was_full) q.push_back(int'(wr_data));
    end
  end

  task automatic chk(string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s got %0d exp %0d", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk("ser_out", int'(ser_out), (mmode == 0) ? 1 : line[0]);
      chk("fifo_level", int'(fifo_level), q.size());
      chk("fifo_full", int'(fifo_full), int'(q.size() == DEPTH));
      chk("fifo_empty", int'(fifo_empty), int'(q.size() == 0));
      chk("tx_idle_irq R9", int'(tx_idle_irq), int'(q.size() == 0 && mmode == 0 && !mbp));
    end
  end

  int run = 0, runmax = 0;
  always @(negedge clk) begin
    if (!ser_out) begin run++; if (run > runmax) runmax = run; end
    else run = 0;
  end

  bit tick_ph = 0;
  initial forever begin
    @(negedge clk); #1;
    tick_ph = ~tick_ph;
    baud_tick = tick_ph;
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic put(int v);
    wr_en = 1; wr_data = 8'(v); cyc(); wr_en = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 5000; k++) begin
      if (mmode == 0 && q.size() == 0 && !mbp) break;
      cyc();
    end
    repeat (3) cyc();
  endtask

  task automatic wait_frame();
    for (int k = 0; k < 500; k++) begin
      if (mmode == 1) break;
      cyc();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc();
    cur_req = "R10";
    chk("reset ser_out", int'(ser_out), 1);
    chk("reset level", int'(fifo_level), 0);
    chk("reset empty", int'(fifo_empty), 1);
    chk("reset full", int'(fifo_full), 0);
    chk("reset irq", int'(tx_idle_irq), 1);
    rst_n = 1; chk_en = 1;
    cyc();

    cur_req = "R1 R3";
    put(8'hA5); put(8'h3C); put(8'h01);
    drain();

    cur_req = "R1 R2";
    for (int c = 0; c < 32; c++) begin
      cfg_len = 2'(c & 3); cfg_par_en = c[2]; cfg_par_odd = c[3]; cfg_two_stop = c[4];
      put(8'h5B + c * 7);
      drain();
    end

    cur_req = "R5";
    cfg_len = 2'd3; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    put(8'h96);
    wait_frame();
    repeat (6) cyc();
    cfg_len = 2'd0; cfg_par_en = 0; cfg_two_stop = 0;
    drain();
    cfg_len = 2'd3;

    cur_req = "R4 R8";
    cfg_flow_en = 1; peer_ready_n = 1;
    for (int k = 0; k < 6; k++) put(8'h10 + k);
    chk("R4 level after overfill", int'(fifo_level), DEPTH);
    chk("R4 full after overfill", int'(fifo_full), 1);
    repeat (100) cyc();
    chk("R8 level held", int'(fifo_level), DEPTH);
    chk("R8 line idle held", int'(ser_out), 1);
    peer_ready_n = 0;
    wait_frame();
    repeat (5) cyc();
    peer_ready_n = 1;
    repeat (150) cyc();
    chk("R8 one frame sent", int'(fifo_level), DEPTH - 1);
    peer_ready_n = 0;
    drain();

    cur_req = "R8";
    cfg_flow_en = 0; peer_ready_n = 1;
    put(8'hC3); put(8'h7E);
    drain();
    peer_ready_n = 0;

    cur_req = "R6 R7";
    put(8'hFF); put(8'h00); put(8'h81);
    wait_frame();
    repeat (4) cyc();
    runmax = 0;
    brk_req = 1; cyc(); brk_req = 0;
    drain();
    chk("R6 break low clocks", runmax, (frame_len() + 1) * TPB * 2);

    cur_req = "R7";
    cfg_flow_en = 1; peer_ready_n = 1;
    brk_req = 1; cyc(); brk_req = 0;
    put(8'h42);
    repeat (150) cyc();
    chk("R7 byte held by flow", int'(fifo_level), 1);
    peer_ready_n = 0;
    drain();
    cfg_flow_en = 0;

    summary();
    $finish;
  end
endmodule